// File: doc/BRIEF.md
# Protection Switch Enable Arbiter

This block decides whether each of four high-side protection switches may conduct. The four are charge, discharge, precharge and predischarge. Several independent sources can hold a switch off. Two host override pins, one for charge and one for discharge, are each brought into the clock domain by a synchronizer. A host-written disable register holds one bit per switch. Three fault flags arrive from the comparators: short-circuit in discharge, overcurrent in charge and overcurrent in discharge. A switch is enabled only while none of the sources that apply to it is active, so releasing one source never re-enables a switch that another source still holds off.

The host configures the block through a simple register-write port. The configuration register picks one of three control styles. In autonomous mode the fault logic alone governs the switches and the override pins are ignored. Partial mode adds the override pins to the live fault logic. In manual mode the pins are also honoured, faults are latched, and a fault stays active until the host clears it. In every mode a fault raises a sticky alert level that the host acknowledges. A status vector shows each active blocking source as one bit.

Top module: `prot_switch_arbiter`

## Requirements
- R1: After reset all four enables are 1, alert is 0 and status is all zeros. The mode is autonomous, both pin selects are 0 and all host-disable bits are 0.
- R2: When its select bit is 1 and the mode is not autonomous, an override pin held high forces its own switch off by the second rising clock edge after it rises. The charge pin affects only the charge switch and the discharge pin affects only the discharge switch.
- R3: An override pin has no effect on any enable or status bit while its select bit is 0, or while the mode is autonomous.
- R4: A write to address 0 loads the configuration. Bits [1:0] hold the mode: 0 is autonomous, 1 is partial, and 2 or 3 is manual. Bit 2 selects the charge pin and bit 3 selects the discharge pin. A write to address 1 loads the host-disable bits: bit 0 is charge, bit 1 is discharge, bit 2 is precharge and bit 3 is predischarge. A 1 holds that switch off, independently of the pins, until the host rewrites the bit as 0.
- R5: Each enable is the inverse of the OR of every blocking source that applies to that switch.
- R6: A short-circuit discharge fault or an overcurrent discharge fault turns off discharge and predischarge. An overcurrent charge fault turns off charge and precharge. Each takes effect one cycle after the fault input is sampled high.
- R7: In autonomous and partial modes, the blocking effect of a fault follows its input with a one-cycle delay, so the switches recover with no host action.
- R8: In manual mode a fault stays latched after its input drops. Writing 1 to bit 1 at address 2 clears it, but only for a fault whose input is low at that clock edge.
- R9: Alert becomes 1 one cycle after any fault input is sampled high, in any mode. It stays 1 until the host writes 1 to bit 0 at address 2, and a fault present at that edge wins over the clear.
- R10: The status bits are as follows. Bit 0 shows the active charge-pin block and bit 1 the active discharge-pin block. Bits 5:2 show the host-disable bits 3:0. Bits 6, 7 and 8 show the blocking state of the short-circuit discharge, overcurrent charge and overcurrent discharge faults.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| chgOffPin | input | 1 | Charge override pin, asynchronous, active high |
| dsgOffPin | input | 1 | Discharge override pin, asynchronous, active high |
| faultScd | input | 1 | Short-circuit discharge fault flag |
| faultOcc | input | 1 | Overcurrent charge fault flag |
| faultOcd | input | 1 | Overcurrent discharge fault flag |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Register write address |
| wrData | input | DATA_W | Register write data |
| chgEn | output | 1 | Charge switch enable |
| dsgEn | output | 1 | Discharge switch enable |
| pchgEn | output | 1 | Precharge switch enable |
| pdsgEn | output | 1 | Predischarge switch enable |
| alert | output | 1 | Sticky fault alert level |
| status | output | 9 | Active blocking sources, one bit each |

## Verification
The bench sweeps every combination of the three modes, both pin selects, both pin levels, all sixteen host-disable patterns and all eight fault patterns. In each case it compares the enables, the alert and the status against an arithmetic model. This sweep shows whether the pins are correctly gated by mode and select, and whether each fault reaches only its own switches. Directed sequences then release one source while another is still active. They also measure the two-edge pin latency. Finally they compare the live fault behaviour of the autonomous and partial modes against the latching of manual mode, including a clear issued while the fault is still present and alert clears in both orders.

// File: rtl/psa_pkg.sv
package psa_pkg;
  localparam int NUM_SW    = 4;  // 0 chg, 1 dsg, 2 pchg, 3 pdsg
  localparam int NUM_FAULT = 3;  // 0 scd, 1 occ, 2 ocd
  localparam int NUM_PIN   = 2;  // 0 chg pin, 1 dsg pin
  localparam int STATUS_W  = NUM_PIN + NUM_SW + NUM_FAULT;

  localparam int ADDR_CFG  = 0;
  localparam int ADDR_HOST = 1;
  localparam int ADDR_CLR  = 2;

  localparam logic [1:0] MODE_AUTO    = 2'd0;
  localparam logic [1:0] MODE_PARTIAL = 2'd1;

  typedef struct packed {
    logic                 loadHost;
    logic [NUM_SW-1:0]    hostData;
    logic                 clrAlert;
    logic                 clrFault;
    logic                 latchFaults;
    logic [NUM_PIN-1:0]   pinBlock;
  } strobe_t;
endpackage

// File: rtl/psa_sync.sv
module psa_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage[0] <= '0;
    else       stage[0] <= din;
  end

  for (genvar g = 1; g < STAGES; g++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[g] <= '0;
      else       stage[g] <= stage[g-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/psa_ctrl.sv
module psa_ctrl
  import psa_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_PIN-1:0] pinSync,
  output strobe_t            strb,
  output logic [1:0]         modeQ,
  output logic [NUM_PIN-1:0] pinActive
);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(ADDR_CFG);
  localparam logic [ADDR_W-1:0] A_HOST = ADDR_W'(ADDR_HOST);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(ADDR_CLR);

  logic [NUM_PIN-1:0] pinSelQ;
  logic hitCfg, hitHost, hitClr;
  logic unusedData;

  assign hitCfg  = wrEn && (wrAddr == A_CFG);
  assign hitHost = wrEn && (wrAddr == A_HOST);
  assign hitClr  = wrEn && (wrAddr == A_CLR);
  assign unusedData = ^wrData[DATA_W-1:NUM_SW];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ   <= MODE_AUTO;
      pinSelQ <= '0;
    end else if (hitCfg) begin
      modeQ   <= wrData[1:0];
      pinSelQ <= wrData[3:2];
    end
  end

  assign pinActive = pinSelQ & {NUM_PIN{modeQ != MODE_AUTO}};

  always_comb begin
    strb.loadHost    = hitHost;
    strb.hostData    = wrData[NUM_SW-1:0];
    strb.clrAlert    = hitClr && wrData[0];
    strb.clrFault    = hitClr && wrData[1];
    strb.latchFaults = modeQ[1];
    strb.pinBlock    = pinActive & pinSync;
  end
endmodule

// File: rtl/psa_datapath.sv
module psa_datapath
  import psa_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic [NUM_FAULT-1:0] faultIn,
  output logic [NUM_SW-1:0]    swEn,
  output logic                 alertQ,
  output logic [NUM_SW-1:0]    hostOffQ,
  output logic [NUM_FAULT-1:0] faultHeldQ,
  output logic [STATUS_W-1:0]  status
);
  localparam logic [NUM_SW-1:0] FAULT_MASK [NUM_FAULT] = '{4'b1010, 4'b0101, 4'b1010};
  localparam logic [NUM_SW-1:0] PIN_MASK   [NUM_PIN]   = '{4'b0001, 4'b0010};

  logic [NUM_SW-1:0] swBlock;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostOffQ   <= '0;
      faultHeldQ <= '0;
      alertQ     <= 1'b0;
    end else begin
      if (strb.loadHost) hostOffQ <= strb.hostData;
      if (strb.latchFaults)
        faultHeldQ <= (faultHeldQ & ~{NUM_FAULT{strb.clrFault}}) | faultIn;
      else
        faultHeldQ <= faultIn;
      alertQ <= (alertQ & ~strb.clrAlert) | (|faultIn);
    end
  end

  always_comb begin
    swBlock = hostOffQ;
    for (int s = 0; s < NUM_SW; s++) begin
      for (int f = 0; f < NUM_FAULT; f++)
        swBlock[s] = swBlock[s] | (faultHeldQ[f] & FAULT_MASK[f][s]);
      for (int p = 0; p < NUM_PIN; p++)
        swBlock[s] = swBlock[s] | (strb.pinBlock[p] & PIN_MASK[p][s]);
    end
  end

  assign swEn   = ~swBlock;
  assign status = {faultHeldQ, hostOffQ, strb.pinBlock};
endmodule

// File: rtl/prot_switch_arbiter.sv
module prot_switch_arbiter
  import psa_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 2,
  parameter int DATA_W      = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                chgOffPin,
  input  logic                dsgOffPin,
  input  logic                faultScd,
  input  logic                faultOcc,
  input  logic                faultOcd,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  output logic                chgEn,
  output logic                dsgEn,
  output logic                pchgEn,
  output logic                pdsgEn,
  output logic                alert,
  output logic [STATUS_W-1:0] status
);
  logic [NUM_PIN-1:0]   pinSync;
  strobe_t              strb;
  logic [1:0]           modeQ;
  logic [NUM_PIN-1:0]   pinActive;
  logic [NUM_SW-1:0]    swEn;
  logic [NUM_SW-1:0]    hostOffQ;
  logic [NUM_FAULT-1:0] faultHeldQ;

  psa_sync #(.STAGES(SYNC_STAGES), .WIDTH(NUM_PIN)) u_sync (
    .clk(clk), .rstN(rstN), .din({dsgOffPin, chgOffPin}), .dout(pinSync)
  );

  psa_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pinSync(pinSync), .strb(strb), .modeQ(modeQ), .pinActive(pinActive)
  );

  psa_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .faultIn({faultOcd, faultOcc, faultScd}),
    .swEn(swEn), .alertQ(alert), .hostOffQ(hostOffQ),
    .faultHeldQ(faultHeldQ), .status(status)
  );

  assign chgEn  = swEn[0];
  assign dsgEn  = swEn[1];
  assign pchgEn = swEn[2];
  assign pdsgEn = swEn[3];
endmodule

// File: rtl/psa_checker.sv
module psa_checker #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              chgOffPin,
  input logic              dsgOffPin,
  input logic              faultScd,
  input logic              faultOcc,
  input logic              faultOcd,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              chgEn,
  input logic              dsgEn,
  input logic              pchgEn,
  input logic              pdsgEn,
  input logic              alert,
  input logic [1:0]        modeQ,
  input logic [1:0]        pinActive,
  input logic [3:0]        hostOffQ,
  input logic [2:0]        faultHeldQ
);
  localparam logic [ADDR_W-1:0] A_HOST = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(2);

  logic [1:0] sinceRst;
  logic anyFault, hostChgWr, alertClrWr, faultClrWr;
  logic unusedBits;

  assign anyFault   = faultScd || faultOcc || faultOcd;
  assign hostChgWr  = wrEn && (wrAddr == A_HOST) && wrData[0];
  assign alertClrWr = wrEn && (wrAddr == A_CLR) && wrData[0];
  assign faultClrWr = wrEn && (wrAddr == A_CLR) && wrData[1];
  assign unusedBits = ^wrData[DATA_W-1:2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  AST_PIN_CHG_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd2 && $past(chgOffPin, 2) && $past(chgOffPin) && chgOffPin && pinActive[0]) |-> !chgEn); // R2
  AST_PIN_DSG_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd2 && $past(dsgOffPin, 2) && $past(dsgOffPin) && dsgOffPin && pinActive[1]) |-> !dsgEn); // R2
  AST_HOST_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd1 && $past(hostChgWr)) |-> !chgEn); // R4
  AST_OCC_ROUTE: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd1 && $past(faultOcc)) |-> (!chgEn && !pchgEn)); // R6
  AST_DSG_ROUTE: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd1 && $past(faultScd || faultOcd)) |-> (!dsgEn && !pdsgEn)); // R6
  AST_AUTO_RECOVER: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd1 && modeQ == 2'd0 && !$past(modeQ[1]) && !$past(anyFault) && hostOffQ == 4'd0)
      |-> (chgEn && dsgEn && pchgEn && pdsgEn)); // R7
  AST_MANUAL_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd1 && $past(modeQ[1]) && $past(faultHeldQ[0]) && !$past(faultClrWr)) |-> faultHeldQ[0]); // R8
  AST_ALERT_SET: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd1 && $past(anyFault)) |-> alert); // R9
  AST_ALERT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd1 && $fell(alert)) |-> $past(alertClrWr)); // R9
endmodule

bind prot_switch_arbiter psa_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .chgOffPin(chgOffPin), .dsgOffPin(dsgOffPin),
  .faultScd(faultScd), .faultOcc(faultOcc), .faultOcd(faultOcd),
  .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .chgEn(chgEn), .dsgEn(dsgEn), .pchgEn(pchgEn), .pdsgEn(pdsgEn), .alert(alert),
  .modeQ(modeQ), .pinActive(pinActive), .hostOffQ(hostOffQ), .faultHeldQ(faultHeldQ)
);

// File: tb/prot_switch_arbiter_bench.sv
module prot_switch_arbiter_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chgOffPin = 1'b0, dsgOffPin = 1'b0;
  logic faultScd = 1'b0, faultOcc = 1'b0, faultOcd = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic chgEn, dsgEn, pchgEn, pdsgEn, alert;
  logic [8:0] status;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  prot_switch_arbiter u_prot_switch_arbiter (
    .clk(clk), .rstN(rstN), .chgOffPin(chgOffPin), .dsgOffPin(dsgOffPin),
    .faultScd(faultScd), .faultOcc(faultOcc), .faultOcd(faultOcd),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .chgEn(chgEn), .dsgEn(dsgEn), .pchgEn(pchgEn), .pdsgEn(pdsgEn),
    .alert(alert), .status(status)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [13:0] model(input int mode, input int sel, input int pins,
                                        input int host, input int f);
    logic pc, pd, h0, h1, h2, h3, scd, occ, ocd;
    pc = (mode != 0) && sel[0] && pins[0];
    pd = (mode != 0) && sel[1] && pins[1];
    h0 = host[0]; h1 = host[1]; h2 = host[2]; h3 = host[3];
    scd = f[0]; occ = f[1]; ocd = f[2];
    return {(f != 0), !(h3 | scd | ocd), !(h2 | occ), !(pd | h1 | scd | ocd),
            !(pc | h0 | occ), ocd, occ, scd, h3, h2, h1, h0, pd, pc};
  endfunction

  function automatic logic [13:0] observed();
    return {alert, pdsgEn, pchgEn, dsgEn, chgEn, status};
  endfunction

  task automatic setFaults(input int f);
    faultScd = f[0]; faultOcc = f[1]; faultOcd = f[2];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    // R1 reset state
    chk("R1 reset outputs", 32'(observed()), 32'({1'b0, 4'hF, 9'h000}));

    // R3 R5 R6 R10 exhaustive sweep
    for (int mode = 0; mode < 3; mode++)
      for (int sel = 0; sel < 4; sel++)
        for (int pins = 0; pins < 4; pins++)
          for (int host = 0; host < 16; host++)
            for (int f = 0; f < 8; f++) begin
              setFaults(0);
              chgOffPin = pins[0]; dsgOffPin = pins[1];
              wr(2'd0, 8'(mode | (sel << 2)));
              wr(2'd1, 8'(host));
              wr(2'd2, 8'h03);
              setFaults(f);
              tick(2);
              chk("R3 R5 R6 R10 sweep", 32'(observed()), 32'(model(mode, sel, pins, host, f)));
            end

    setFaults(0); chgOffPin = 0; dsgOffPin = 0;
    wr(2'd1, 8'h00); wr(2'd2, 8'h03); tick(3);

    // R2 two-edge latency, partial mode, charge pin only
    wr(2'd0, 8'h05);
    tick(2);
    chgOffPin = 1'b1;
    tick(2);
    chk("R2 charge pin off by second edge", {dsgEn, chgEn}, 2'b10);

    // R4 host disable persists after pin release
    wr(2'd1, 8'h01);
    chgOffPin = 1'b0;
    tick(4);
    chk("R4 host keeps charge off after pin release", chgEn, 1'b0);
    wr(2'd1, 8'h00);
    chk("R4 charge on after host bit cleared", chgEn, 1'b1);

    // R5 pin release with host disable of discharge
    wr(2'd0, 8'h09);
    dsgOffPin = 1'b1; tick(3);
    wr(2'd1, 8'h02);
    dsgOffPin = 1'b0; tick(3);
    chk("R5 discharge held by remaining source", dsgEn, 1'b0);
    wr(2'd1, 8'h00);
    chk("R5 discharge back once all sources clear", dsgEn, 1'b1);

    // R7 autonomous recovery
    wr(2'd0, 8'h00);
    setFaults(2); tick(1);
    chk("R7 auto fault blocks charge", {pchgEn, chgEn}, 2'b00);
    setFaults(0); tick(1);
    chk("R7 auto recovers without host", {pchgEn, chgEn}, 2'b11);
    // R7 partial mode recovery
    wr(2'd0, 8'h01);
    setFaults(4); tick(1);
    chk("R7 partial fault blocks discharge", {pdsgEn, dsgEn}, 2'b00);
    setFaults(0); tick(1);
    chk("R7 partial recovers", {pdsgEn, dsgEn}, 2'b11);

    // R8 manual latch
    wr(2'd2, 8'h01);
    wr(2'd0, 8'h02);
    setFaults(1); tick(1); setFaults(0); tick(5);
    chk("R8 manual fault stays latched", {status[6], pdsgEn, dsgEn}, 3'b100);
    wr(2'd2, 8'h02);
    chk("R8 clear releases latched fault", {status[6], pdsgEn, dsgEn}, 3'b011);
    setFaults(1); tick(1);
    wr(2'd2, 8'h02);
    setFaults(0); tick(3);
    chk("R8 clear during active fault ignored", dsgEn, 1'b0);
    wr(2'd2, 8'h02);
    chk("R8 later clear succeeds", dsgEn, 1'b1);
    // R4 mode code 3 acts as manual
    wr(2'd0, 8'h03);
    setFaults(2); tick(1); setFaults(0); tick(3);
    chk("R4 mode 3 latches like manual", chgEn, 1'b0);
    wr(2'd2, 8'h02);
    chk("R4 mode 3 clear", chgEn, 1'b1);

    // R9 alert behaviour
    wr(2'd2, 8'h01);
    chk("R9 alert cleared", alert, 1'b0);
    setFaults(4); tick(1); setFaults(0);
    chk("R9 alert raised", alert, 1'b1);
    tick(5);
    wr(2'd2, 8'h02);
    chk("R9 fault clear leaves alert", alert, 1'b1);
    setFaults(1);
    wr(2'd2, 8'h01);
    chk("R9 fault wins over alert clear", alert, 1'b1);
    setFaults(0);
    wr(2'd2, 8'h01);
    chk("R9 alert clear", alert, 1'b0);

    // R3 autonomous mode ignores selected pins
    wr(2'd2, 8'h03);
    wr(2'd0, 8'h0C);
    chgOffPin = 1'b1; dsgOffPin = 1'b1; tick(4);
    chk("R3 autonomous ignores pins", 32'(observed()), 32'({1'b0, 4'hF, 9'h000}));

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule